// File: doc/BRIEF.md
# Tamper Detection and Timestamp Unit

This block watches two tamper pins. Each pin can be set to catch a single edge, or to wait until the pin has held its active level over a run of filtered samples. A tamper event does four things. It sets a sticky per-pin flag. It can raise an interrupt. It wipes a bank of twenty 32-bit backup words. It can also record a timestamp taken from an external time word. The same two pins can also act as a direct timestamp trigger. A select bit picks which of the two pins does this.

Software reaches all of this through a small word-addressed register port. The configuration word is at address 0, the status word at address 1 and the captured time at address 2. The backup words sit at addresses 16 to 35. The backup bank has its own reset, so a system reset does not destroy its contents.

Top module: `tamper_unit`

## Requirements
- R1: After system reset the configuration word, the status word, the captured time and `irq` all read 0.
- R2: Edge mode applies when filter field CFG[9:8] is 0. An enabled input (CFG[0] for pin 0, CFG[1] for pin 1) raises its event on a rising edge when its trigger bit (CFG[2], CFG[3]) is 0, and on a falling edge when that bit is 1. The opposite edge, or any edge on a disabled input, raises nothing.
- R3: A non-zero filter field N selects level mode. The active level is high when the trigger bit is 0 and low when it is 1. The pin is sampled once every 2^R clock cycles, where R is the rate field CFG[11:10]. An event fires when 2^N consecutive samples are all at the active level. Any cycle spent at the inactive level restarts the count.
- R4: Tamper flags sit at STAT[2] (pin 0) and STAT[3] (pin 1). They stay set until a write to STAT puts 0 in that bit. Writing 1 leaves a flag as it is. If an event and a clearing write arrive in the same cycle, the flag ends up set.
- R5: Any tamper event sets all twenty backup words to 0. A system reset leaves them unchanged.
- R6: `irq` equals the interrupt enable CFG[4] ANDed with the OR of the two tamper flags.
- R7: When CFG[5] is set, a tamper event also takes a timestamp in the same cycle that the tamper flag is set. If STAT[0] (timestamp flag) is clear, this sets STAT[0] and stores the time word. If STAT[0] is already set, it sets STAT[1] (overflow) and leaves the stored time unchanged.
- R8: A write of 0 to STAT[0] clears the timestamp flag only if STAT was read with STAT[0]=1 since the last STAT write. Without such a read the write has no effect on the flag.
- R9: Timestamp select CFG[6]=1 routes the timestamp to pin 1. Such a write is ignored, and the bit reads 0, whenever the same write leaves pin 0 enabled in level mode.
- R10: With CFG[7] set, a rising edge on the selected timestamp pin takes a timestamp. No such direct timestamp is taken when that pin is an enabled tamper input in level mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | System reset, active low |
| bkp_rst_n | input | 1 | Backup bank reset, active low, asynchronous |
| tamp_pin | input | 2 | Asynchronous tamper pins; these also serve as timestamp pins |
| time_in | input | 32 | Current time/date word |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 6 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from `addr` |
| irq | output | 1 | Tamper interrupt request |

## Verification
The embedded assertions are checked on every cycle. They cover these properties:
- An edge event lasts one cycle.
- The filter count restarts when the pin goes inactive.
- The backup bank is all zero in the cycle after a wipe.
- Tamper flags and timestamp flags follow their events.
- The timestamp flag only falls after an arming read.
- The captured time holds while the flag is set.
- The illegal select combination can never be stored.

Some behaviour can only be shown by the bench's scenarios:
- The exact sample counts that separate a filtered pulse that fires from one that does not, across filter and rate settings.
- The survival of backup data across a system reset.
- The event-beats-clear collision.
- Suppression of a direct timestamp on a filtered pin.

// File: rtl/tamp_pkg.sv
package tamp_pkg;
  localparam int NTAMP     = 2;
  localparam int BKP_WORDS = 20;
  localparam int DW        = 32;
  localparam int AW        = 6;
  localparam int FCW       = 4;   // filter sample counter width
  localparam int TCW       = 3;   // sample tick divider width
  localparam int BKP_IW    = $clog2(BKP_WORDS);

  localparam logic [AW-1:0] A_CFG  = 6'd0;
  localparam logic [AW-1:0] A_STAT = 6'd1;
  localparam logic [AW-1:0] A_TIME = 6'd2;
  localparam logic [AW-1:0] A_BKP0 = 6'd16;

  localparam int CFG_W  = 12;
  localparam int STAT_TSF  = 0;
  localparam int STAT_OVF  = 1;
  localparam int STAT_TF0  = 2;

  // configuration word, MSB first: [11:10] rate, [9:8] filt, [7] ts_en,
  // [6] ts_sel, [5] ts_on_tamp, [4] irq_en, [3:2] trg, [1:0] en
  typedef struct packed {
    logic [1:0]       rate;
    logic [1:0]       filt;
    logic             ts_en;
    logic             ts_sel;
    logic             ts_on_tamp;
    logic             irq_en;
    logic [NTAMP-1:0] trg;
    logic [NTAMP-1:0] en;
  } cfg_t;

  // number of consecutive samples needed in level mode
  function automatic logic [FCW-1:0] filt_need(input logic [1:0] f);
    return FCW'(1) << f;
  endfunction

  // mask applied to the free-running divider: tick every 2^rate cycles
  function automatic logic [TCW-1:0] tick_mask(input logic [1:0] r);
    return TCW'((TCW'(1) << r) - TCW'(1));
  endfunction

  // drop a timestamp select to pin 1 that collides with filtered pin 0
  function automatic cfg_t cfg_sanitize(input cfg_t c);
    cfg_t o;
    o = c;
    if (c.filt != 2'd0 && c.en[0]) o.ts_sel = 1'b0;
    return o;
  endfunction

  function automatic logic is_bkp(input logic [AW-1:0] a);
    return (a >= A_BKP0) && (a < A_BKP0 + AW'(BKP_WORDS));
  endfunction
endpackage

// File: rtl/tamp_sync.sv
module tamp_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta   <= '0;
      q_sync <= '0;
    end else begin
      meta   <= d_async;
      q_sync <= meta;
    end
  end
endmodule

// File: rtl/tamp_detect.sv
module tamp_detect
  import tamp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       trg,
  input  logic [1:0] filt,
  input  logic       tick,
  input  logic       pin_s,
  output logic       evt
);
  logic           s_d;
  logic           active;
  logic           edge_hit;
  logic           lvl_hit;
  logic           lvl_mode;
  logic [FCW-1:0] need;
  logic [FCW-1:0] cnt;

  assign lvl_mode = (filt != 2'd0);
  assign need     = filt_need(filt);
  assign active   = trg ? ~pin_s : pin_s;
  assign edge_hit = trg ? (s_d & ~pin_s) : (~s_d & pin_s);
  assign lvl_hit  = lvl_mode && active && tick && (cnt == need - FCW'(1));
  assign evt      = en & (lvl_mode ? lvl_hit : edge_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s_d <= 1'b0;
    else        s_d <= pin_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           cnt <= '0;
    else if (!en || !lvl_mode || !active) cnt <= '0;
    else if (tick && cnt != need)         cnt <= cnt + FCW'(1);
  end

  // R2: an edge event lasts exactly one cycle while the trigger setup holds
  p_edge_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !lvl_mode) |=> (!evt || !$stable(trg) || !$stable(filt) || $rose(en)));

  // R3: an inactive sample empties the filter count
  p_filt_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && lvl_mode && !active) |=> (cnt == '0));

  // R3: after a level event the counter sits saturated, so it cannot refire
  p_filt_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && lvl_mode && $stable(filt)) |=> (!evt));
endmodule

// File: rtl/tamp_ts_unit.sv
module tamp_ts_unit
  import tamp_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,
  input  logic [DW-1:0] time_in,
  input  logic          stat_rd,
  input  logic          stat_wr,
  input  logic          wr_tsf,
  input  logic          wr_ovf,
  output logic          tsf,
  output logic          tsovf,
  output logic [DW-1:0] time_q
);
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              armed <= 1'b0;
    else if (stat_rd && tsf) armed <= 1'b1;
    else if (stat_wr)        armed <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tsf    <= 1'b0;
      time_q <= '0;
    end else if (cap) begin
      tsf <= 1'b1;
      if (!tsf) time_q <= time_in;
    end else if (stat_wr && !wr_tsf && armed) begin
      tsf <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 tsovf <= 1'b0;
    else if (cap && tsf)        tsovf <= 1'b1;
    else if (stat_wr && !wr_ovf) tsovf <= 1'b0;
  end

  // R8: the timestamp flag only drops after an arming read and a STAT write
  p_tsf_clear_guard_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tsf) |-> ($past(armed) && $past(stat_wr)));

  // R7: overflow only rises when a capture meets an already set flag
  p_ovf_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tsovf) |-> ($past(tsf) && $past(cap)));

  // R7: the captured time holds while the flag stays set
  p_time_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tsf && !cap) |=> $stable(time_q));
endmodule

// File: rtl/tamp_bkp_bank.sv
module tamp_bkp_bank
  import tamp_pkg::*;
(
  input  logic                           clk,
  input  logic                           bkp_rst_n,
  input  logic                           wipe,
  input  logic                           wr_en,
  input  logic [BKP_IW-1:0]              idx,
  input  logic [DW-1:0]                  wdata,
  output logic [BKP_WORDS-1:0][DW-1:0]   words
);
  for (genvar g = 0; g < BKP_WORDS; g++) begin : g_word
    always_ff @(posedge clk or negedge bkp_rst_n) begin
      if (!bkp_rst_n)                        words[g] <= '0;
      else if (wipe)                         words[g] <= '0;
      else if (wr_en && idx == BKP_IW'(g))   words[g] <= wdata;
    end
  end

  // R5: a wipe leaves the whole bank empty in the next cycle
  p_wipe_r5: assert property (@(posedge clk) disable iff (!bkp_rst_n)
    wipe |=> (words == '0));

  // R5: without a wipe or a write the bank content does not move
  p_bank_hold_r5: assert property (@(posedge clk) disable iff (!bkp_rst_n)
    (!wipe && !wr_en) |=> $stable(words));
endmodule

// File: rtl/tamper_unit.sv
module tamper_unit
  import tamp_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bkp_rst_n,
  input  logic [1:0]    tamp_pin,
  input  logic [31:0]   time_in,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [5:0]    addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  output logic          irq
);
  cfg_t                         cfg;
  logic [NTAMP-1:0]             pin_s;
  logic [NTAMP-1:0]             pin_d;
  logic [NTAMP-1:0]             tamp_evt;
  logic [NTAMP-1:0]             tf;
  logic                         tamp_any;
  logic [TCW-1:0]               tick_cnt;
  logic                         tick;
  logic                         cfg_wr;
  logic                         stat_wr;
  logic                         stat_rd;
  logic                         bkp_wr;
  logic [BKP_IW-1:0]            bkp_idx;
  logic [BKP_WORDS-1:0][DW-1:0] bkp_words;
  logic                         ts_rise;
  logic                         ts_blocked;
  logic                         ts_direct;
  logic                         ts_cap;
  logic                         tsf;
  logic                         tsovf;
  logic [DW-1:0]                time_q;

  // register strobes
  assign cfg_wr  = wr_en && (addr == A_CFG);
  assign stat_wr = wr_en && (addr == A_STAT);
  assign stat_rd = rd_en && (addr == A_STAT);
  assign bkp_wr  = wr_en && is_bkp(addr);
  assign bkp_idx = BKP_IW'(addr - A_BKP0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg <= '0;
    else if (cfg_wr) cfg <= cfg_sanitize(cfg_t'(wdata[CFG_W-1:0]));
  end

  // sample-rate divider
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_cnt <= '0;
    else        tick_cnt <= tick_cnt + TCW'(1);
  end
  assign tick = ((tick_cnt & tick_mask(cfg.rate)) == '0);

  tamp_sync #(.W(NTAMP)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (tamp_pin),
    .q_sync  (pin_s)
  );

  for (genvar g = 0; g < NTAMP; g++) begin : g_det
    tamp_detect u_det (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (cfg.en[g]),
      .trg   (cfg.trg[g]),
      .filt  (cfg.filt),
      .tick  (tick),
      .pin_s (pin_s[g]),
      .evt   (tamp_evt[g])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                tf[g] <= 1'b0;
      else if (tamp_evt[g])                      tf[g] <= 1'b1;
      else if (stat_wr && !wdata[STAT_TF0 + g])  tf[g] <= 1'b0;
    end

    // R4: an event always leaves its flag set, even against a clearing write
    p_flag_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tamp_evt[g] |=> tf[g]);
  end

  assign tamp_any = |tamp_evt;

  // direct timestamp path on the selected pin
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_d <= '0;
    else        pin_d <= pin_s;
  end
  assign ts_rise    = pin_s[cfg.ts_sel] & ~pin_d[cfg.ts_sel];
  assign ts_blocked = (cfg.filt != 2'd0) && cfg.en[cfg.ts_sel];
  assign ts_direct  = cfg.ts_en && ts_rise && !ts_blocked;
  assign ts_cap     = ts_direct || (cfg.ts_on_tamp && tamp_any);

  tamp_ts_unit u_ts (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap     (ts_cap),
    .time_in (time_in),
    .stat_rd (stat_rd),
    .stat_wr (stat_wr),
    .wr_tsf  (wdata[STAT_TSF]),
    .wr_ovf  (wdata[STAT_OVF]),
    .tsf     (tsf),
    .tsovf   (tsovf),
    .time_q  (time_q)
  );

  tamp_bkp_bank u_bkp (
    .clk       (clk),
    .bkp_rst_n (bkp_rst_n),
    .wipe      (tamp_any),
    .wr_en     (bkp_wr),
    .idx       (bkp_idx),
    .wdata     (wdata),
    .words     (bkp_words)
  );

  assign irq = cfg.irq_en & (|tf);

  always_comb begin
    rdata = '0;
    if (addr == A_CFG)       rdata = DW'(cfg);
    else if (addr == A_STAT) rdata = DW'({tf, tsovf, tsf});
    else if (addr == A_TIME) rdata = time_q;
    else if (is_bkp(addr))   rdata = bkp_words[bkp_idx];
  end

  // R9: pin 1 is never the timestamp source while pin 0 is a filtered tamper
  p_sel_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg.ts_sel && cfg.en[0] && (cfg.filt != 2'd0)));

  // R7: a tamper event with timestamp-on-tamper sets the timestamp flag
  p_ts_on_tamp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tamp_any && cfg.ts_on_tamp) |=> tsf);

  // R6: an event under an enabled interrupt raises irq next cycle
  p_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tamp_any && cfg.irq_en && !cfg_wr) |=> irq);

  // R10: a filtered, enabled selected pin never yields a direct timestamp
  p_ts_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ts_blocked && !(cfg.ts_on_tamp && tamp_any) && !tsf) |=> !tsf);
endmodule

// File: tb/tb_tamper_unit.sv
module tb_tamper_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bkp_rst_n = 1'b0;
  logic [1:0]  tamp_pin = 2'b00;
  logic [31:0] time_in = 32'h0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [5:0]  addr = 6'd0;
  logic [31:0] wdata = 32'h0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  localparam logic [5:0] CFG = 6'd0, STAT = 6'd1, TIMEW = 6'd2, BKP0 = 6'd16;

  always #2 clk = ~clk;

  tamper_unit dut (
    .clk(clk), .rst_n(rst_n), .bkp_rst_n(bkp_rst_n), .tamp_pin(tamp_pin),
    .time_in(time_in), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  function automatic logic [31:0] mkcfg(input int en, input int trg, input int irqe,
                                        input int tot, input int sel, input int tse,
                                        input int filt, input int rate);
    return 32'(en) | (32'(trg) << 2) | (32'(irqe) << 4) | (32'(tot) << 5) |
           (32'(sel) << 6) | (32'(tse) << 7) | (32'(filt) << 8) | (32'(rate) << 10);
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic quiet(input logic [1:0] pins);
    wr(CFG, 32'h0);
    @(negedge clk) tamp_pin = pins;
    idle(5);
    wr(STAT, 32'h0);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    idle(3);
    rst_n = 1'b1; bkp_rst_n = 1'b1;
    idle(2);

    // R1 reset state
    rd(CFG, d);   chk("R1 cfg", d, 0);
    rd(STAT, d);  chk("R1 stat", d, 0);
    rd(TIMEW, d); chk("R1 time", d, 0);
    chk("R1 irq", 32'(irq), 0);

    // R2 edge sweep: each pin, each trigger polarity
    for (int i = 0; i < 2; i++) begin
      for (int t = 0; t < 2; t++) begin
        logic [1:0] base;
        base = (t != 0) ? 2'b11 : 2'b00;
        quiet(base);
        wr(CFG, mkcfg(1 << i, t << i, 0, 0, 0, 0, 0, 0));
        @(negedge clk) tamp_pin[1-i] = ~tamp_pin[1-i];  // disabled pin moves
        @(negedge clk) tamp_pin[i] = ~base[i];          // active edge
        idle(5);
        rd(STAT, d); chk("R2 active edge", d, 32'(1) << (2 + i));
        wr(STAT, 32'h0);
        @(negedge clk) tamp_pin[i] = base[i];           // opposite edge
        tamp_pin[1-i] = ~tamp_pin[1-i];
        idle(5);
        rd(STAT, d); chk("R2 opposite or disabled edge", d, 0);
      end
    end

    // R3 filter sweep over filter and rate fields
    for (int n = 1; n < 4; n++) begin
      for (int r = 0; r < 3; r++) begin
        int need, per;
        need = 1 << n; per = 1 << r;
        // short pulse: at most need-1 samples
        quiet(2'b00);
        wr(CFG, mkcfg(1, 0, 0, 0, 0, 0, n, r));
        @(negedge clk) tamp_pin[0] = 1'b1;
        idle((need - 1) * per);
        tamp_pin[0] = 1'b0;
        idle(5);
        rd(STAT, d); chk("R3 short pulse", d, 0);
        // two short pulses split by an inactive gap: count restarts
        @(negedge clk) tamp_pin[0] = 1'b1;
        idle((need - 1) * per);
        tamp_pin[0] = 1'b0;
        idle(2);
        tamp_pin[0] = 1'b1;
        idle((need - 1) * per);
        tamp_pin[0] = 1'b0;
        idle(5);
        rd(STAT, d); chk("R3 restart after gap", d, 0);
        // long hold: at least need samples
        @(negedge clk) tamp_pin[0] = 1'b1;
        idle(need * per + per + 2);
        idle(4);
        rd(STAT, d); chk("R3 long hold", d, 32'h4);
        @(negedge clk) tamp_pin[0] = 1'b0;
      end
    end
    // R3 active-low level on pin 1
    quiet(2'b11);
    wr(CFG, mkcfg(2, 2, 0, 0, 0, 0, 2, 1));
    @(negedge clk) tamp_pin[1] = 1'b0;
    idle(4 * 2 + 8);
    rd(STAT, d); chk("R3 active low level", d, 32'h8);

    // R4 clear-vs-event collision and write-1 keeps flag
    quiet(2'b00);
    wr(CFG, mkcfg(1, 0, 0, 0, 0, 0, 0, 0));
    @(negedge clk) tamp_pin[0] = 1'b1;
    @(posedge clk);
    @(posedge clk);
    wr(STAT, 32'h0);
    rd(STAT, d); chk("R4 event wins over clear", d, 32'h4);
    wr(STAT, 32'hC);
    rd(STAT, d); chk("R4 write one keeps flag", d, 32'h4);
    wr(STAT, 32'h0);
    rd(STAT, d); chk("R4 write zero clears", d, 0);

    // R6 interrupt
    quiet(2'b00);
    wr(CFG, mkcfg(1, 0, 1, 0, 0, 0, 0, 0));
    @(negedge clk) tamp_pin[0] = 1'b1;
    idle(5);
    chk("R6 irq with enable", 32'(irq), 1);
    wr(STAT, 32'h0);
    chk("R6 irq after clear", 32'(irq), 0);
    quiet(2'b00);
    wr(CFG, mkcfg(1, 0, 0, 0, 0, 0, 0, 0));
    @(negedge clk) tamp_pin[0] = 1'b1;
    idle(5);
    chk("R6 irq masked", 32'(irq), 0);

    // R5 backup bank: survives system reset, wiped by tamper
    quiet(2'b00);
    for (int k = 0; k < 20; k++) wr(BKP0 + 6'(k), 32'(k) * 32'h01010101 + 32'h5);
    @(negedge clk) rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(2);
    rd(CFG, d); chk("R1 cfg after system reset", d, 0);
    for (int k = 0; k < 20; k++) begin
      rd(BKP0 + 6'(k), d);
      chk("R5 kept over system reset", d, 32'(k) * 32'h01010101 + 32'h5);
    end
    wr(CFG, mkcfg(2, 0, 0, 0, 0, 0, 0, 0));
    @(negedge clk) tamp_pin[1] = 1'b1;
    idle(5);
    for (int k = 0; k < 20; k++) begin
      rd(BKP0 + 6'(k), d);
      chk("R5 wiped by tamper", d, 0);
    end

    // R7 / R8 timestamp on tamper, overflow, read-before-clear
    quiet(2'b00);
    time_in = 32'h1234_0001;
    wr(CFG, mkcfg(2, 0, 0, 1, 0, 0, 0, 0));
    @(negedge clk) tamp_pin[1] = 1'b1;
    idle(5);
    wr(STAT, 32'h0);
    rd(STAT, d); chk("R8 clear without read ignored", d, 32'h1);
    rd(TIMEW, d); chk("R7 captured time", d, 32'h1234_0001);
    time_in = 32'h9999_0002;
    @(negedge clk) tamp_pin[1] = 1'b0;
    idle(4);
    tamp_pin[1] = 1'b1;
    idle(5);
    rd(STAT, d); chk("R7 overflow on second capture", d, 32'hB);
    rd(TIMEW, d); chk("R7 time kept on overflow", d, 32'h1234_0001);
    wr(STAT, 32'h0);
    rd(STAT, d); chk("R8 clear after read", d, 0);

    // R9 select legality
    wr(CFG, mkcfg(1, 0, 0, 0, 1, 0, 1, 0));
    rd(CFG, d); chk("R9 select dropped", d, mkcfg(1, 0, 0, 0, 0, 0, 1, 0));
    wr(CFG, mkcfg(0, 0, 0, 0, 1, 0, 1, 0));
    rd(CFG, d); chk("R9 select kept pin0 off", d, mkcfg(0, 0, 0, 0, 1, 0, 1, 0));
    wr(CFG, mkcfg(1, 0, 0, 0, 1, 0, 0, 0));
    rd(CFG, d); chk("R9 select kept edge mode", d, mkcfg(1, 0, 0, 0, 1, 0, 0, 0));

    // R10 direct timestamp on pin 1
    quiet(2'b00);
    time_in = 32'hCAFE_0003;
    wr(CFG, mkcfg(0, 0, 0, 0, 1, 1, 0, 0));
    @(negedge clk) tamp_pin[1] = 1'b1;
    idle(5);
    rd(STAT, d); chk("R10 direct timestamp", d, 32'h1);
    rd(TIMEW, d); chk("R10 direct time", d, 32'hCAFE_0003);
    wr(STAT, 32'h0);
    rd(STAT, d); chk("R10 cleared", d, 0);
    // R10 suppressed on filtered pin 0 (active low, one-cycle dip)
    quiet(2'b11);
    wr(CFG, mkcfg(1, 1, 0, 0, 0, 1, 1, 0));
    @(negedge clk) tamp_pin[0] = 1'b0;
    @(negedge clk) tamp_pin[0] = 1'b1;
    idle(6);
    rd(STAT, d); chk("R10 blocked on filtered pin", d, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule